// File: doc/BRIEF.md
# Auto-Reload Decrementer with Interrupt Status

This block is a down-counter that advances on a time-base rate strobe rather than on every clock. Software writes a start value into the count register. The count then drops by one on each strobe. When it steps from one to zero, an expiry event sets a sticky status flag. A separate enable bit gates that flag onto a single interrupt line.

When automatic reload is switched on and the reload register holds a nonzero value, the count takes the reload value at the moment it would have reached zero. The block then keeps producing periodic events. A reload value of zero leaves the counter parked at zero, so a zero reload can never retrigger endlessly. Software clears the flag by writing a one to it.

The register port is a plain single-cycle write strobe with a combinational read. It carries no valid/ready handshake because every access completes in the cycle it is presented and there is no data stream to throttle.

Top module: `dcr_decrementer`

## Requirements
- R1: The count drops by exactly one on each clock edge where `rate_tick` is high and the count is nonzero. Without a strobe or a software load it holds its value.
- R2: An expiry event happens only on a strobe that takes the count from one to zero. A count already at zero stays at zero and raises no further events while no load occurs.
- R3: An expiry sets status bit 27 (address 3) on the same clock edge, whether or not the interrupt is enabled.
- R4: With control bit 22 (auto-reload) set and a nonzero reload register, an expiry loads the reload value into the count instead of zero.
- R5: With auto-reload set and a reload register of zero, an expiry leaves the count at zero, and later strobes raise no more events.
- R6: Writing address 3 with bit 27 set clears the status bit, and writing a zero there has no effect. An expiry in the same cycle as a clearing write leaves the bit set.
- R7: `irq` is high exactly when status bit 27 and control bit 26 (interrupt enable) are both set.
- R8: A software write to the count (address 0) takes priority over a decrement or reload in the same cycle, and that cycle raises no expiry.
- R9: The read port returns the count at address 0, the reload register at address 1, the control register at address 2 and status at address 3. Only control bits 26 and 22 and status bit 27 read as ones; all other bits read zero.
- R10: Reset clears the control register, the status bit, the count and the reload register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_tick | input | 1 | Time-base rate strobe, one decrement per high cycle |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Write address: 0 count, 1 reload, 2 control, 3 status |
| reg_wr_data | input | DATA_W | Write data |
| reg_rd_addr | input | 2 | Read address, same map as writes |
| reg_rd_data | output | DATA_W | Combinational read data |
| irq | output | 1 | Decrementer interrupt request |

## Verification
The bench builds the block with the default 32-bit width. It loads only small start and reload values, so expiry, reload and the parked-at-zero state are all reached within a handful of strobes. It holds the strobe high for bursts and drops it for idle stretches. Against those bursts it lines up the same-cycle collisions: a count write against a pending expiry, and a status clear against an expiry.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] AD_COUNT  = 2'd0;
  localparam logic [ADDR_W-1:0] AD_RELOAD = 2'd1;
  localparam logic [ADDR_W-1:0] AD_CTRL   = 2'd2;
  localparam logic [ADDR_W-1:0] AD_STATUS = 2'd3;

  // bit positions that software decodes
  localparam int IE_BIT   = 26;
  localparam int ARE_BIT  = 22;
  localparam int STAT_BIT = 27;
endpackage

// File: rtl/dcr_count_core.sv
module dcr_count_core #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              auto_en,
  input  logic [DATA_W-1:0] reload_val,
  output logic [DATA_W-1:0] count,
  output logic              expire
);
  localparam logic [DATA_W-1:0] ONE  = DATA_W'(1);
  localparam logic [DATA_W-1:0] ZERO = '0;

  logic at_one;
  logic use_reload;

  assign at_one     = (count == ONE);
  assign expire     = tick && !load && at_one;
  assign use_reload = auto_en && (reload_val != ZERO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= ZERO;
    end else if (load) begin
      count <= load_val;
    end else if (tick && (count != ZERO)) begin
      if (at_one && use_reload) count <= reload_val;
      else                      count <= count - ONE;
    end
  end

  // R1
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(count));

  // R2
  zero_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((count == ZERO) && !load) |=> (count == ZERO));

  // R4
  reload_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && auto_en && (reload_val != ZERO)) |=> (count == $past(reload_val)));

  // R8
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(load_val)));
endmodule

// File: rtl/dcr_ctrl_regs.sv
module dcr_ctrl_regs #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_reload,
  input  logic              wr_ctrl,
  input  logic              wr_status,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              expire,
  output logic [DATA_W-1:0] reload_val,
  output logic              int_en,
  output logic              auto_en,
  output logic              status
);
  import dcr_pkg::*;

  logic clr_req;
  assign clr_req = wr_status && wr_data[STAT_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_val <= '0;
      int_en     <= 1'b0;
      auto_en    <= 1'b0;
      status     <= 1'b0;
    end else begin
      if (wr_reload) reload_val <= wr_data;
      if (wr_ctrl) begin
        int_en  <= wr_data[IE_BIT];
        auto_en <= wr_data[ARE_BIT];
      end
      if (expire)       status <= 1'b1;
      else if (clr_req) status <= 1'b0;
    end
  end

  // R3
  expire_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> status);

  // R6
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !expire) |=> !status);

  // R6
  zero_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status && wr_status && !wr_data[STAT_BIT]) |=> status);
endmodule

// File: rtl/dcr_decrementer.sv
module dcr_decrementer #(
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rate_tick,
  input  logic                       reg_wr_en,
  input  logic [dcr_pkg::ADDR_W-1:0] reg_wr_addr,
  input  logic [DATA_W-1:0]          reg_wr_data,
  input  logic [dcr_pkg::ADDR_W-1:0] reg_rd_addr,
  output logic [DATA_W-1:0]          reg_rd_data,
  output logic                       irq
);
  import dcr_pkg::*;

  logic              wr_count, wr_reload, wr_ctrl, wr_status;
  logic [DATA_W-1:0] count, reload_val;
  logic              expire, int_en, auto_en, status;

  assign wr_count  = reg_wr_en && (reg_wr_addr == AD_COUNT);
  assign wr_reload = reg_wr_en && (reg_wr_addr == AD_RELOAD);
  assign wr_ctrl   = reg_wr_en && (reg_wr_addr == AD_CTRL);
  assign wr_status = reg_wr_en && (reg_wr_addr == AD_STATUS);

  dcr_count_core #(.DATA_W(DATA_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (rate_tick),
    .load       (wr_count),
    .load_val   (reg_wr_data),
    .auto_en    (auto_en),
    .reload_val (reload_val),
    .count      (count),
    .expire     (expire)
  );

  dcr_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_reload  (wr_reload),
    .wr_ctrl    (wr_ctrl),
    .wr_status  (wr_status),
    .wr_data    (reg_wr_data),
    .expire     (expire),
    .reload_val (reload_val),
    .int_en     (int_en),
    .auto_en    (auto_en),
    .status     (status)
  );

  assign irq = status && int_en;

  always_comb begin
    reg_rd_data = '0;
    unique case (reg_rd_addr)
      AD_COUNT:  reg_rd_data = count;
      AD_RELOAD: reg_rd_data = reload_val;
      AD_CTRL: begin
        reg_rd_data[IE_BIT]  = int_en;
        reg_rd_data[ARE_BIT] = auto_en;
      end
      default:   reg_rd_data[STAT_BIT] = status;
    endcase
  end

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !reg_wr_data[IE_BIT]) |=> !irq);
endmodule

// File: tb/dcr_decrementer_bench.sv
`timescale 1ns/1ps
module dcr_decrementer_bench;
  localparam int DATA_W = 32;
  localparam logic [31:0] IE  = 32'h0400_0000;
  localparam logic [31:0] ARE = 32'h0040_0000;
  localparam logic [31:0] DIS = 32'h0800_0000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rate_tick = 1'b0;
  logic              reg_wr_en = 1'b0;
  logic [1:0]        reg_wr_addr = '0;
  logic [DATA_W-1:0] reg_wr_data = '0;
  logic [1:0]        reg_rd_addr = '0;
  logic [DATA_W-1:0] reg_rd_data;
  logic              irq;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [1:0]        q_addr[$];
  logic [DATA_W-1:0] q_data[$];
  logic              q_irq[$];
  string             q_tag[$];

  always #4 clk = ~clk;

  dcr_decrementer #(.DATA_W(DATA_W)) u_dcr_decrementer (
    .clk(clk), .rst_n(rst_n), .rate_tick(rate_tick),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data), .irq(irq)
  );

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    rate_tick = 1'b1;
    repeat (n) @(negedge clk);
    rate_tick = 1'b0;
  endtask

  task automatic chk(input logic [1:0] a, input logic [31:0] d, input logic i, input string tag);
    reg_rd_addr = a;
    q_addr.push_back(a); q_data.push_back(d); q_irq.push_back(i); q_tag.push_back(tag);
    @(negedge clk);
  endtask

  // monitor: pops expected items and compares against live outputs
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q_addr.size() > 0) begin
        logic [1:0] a; logic [31:0] d; logic i; string t;
        a = q_addr.pop_front(); d = q_data.pop_front();
        i = q_irq.pop_front();  t = q_tag.pop_front();
        tests++;
        if (reg_rd_data !== d || irq !== i) begin
          fails++;
          $display("FAIL %s addr=%0d data=%h irq=%b expected data=%h irq=%b",
                   t, a, reg_rd_data, irq, d, i);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(2, 0, 0, "R10 ctrl after reset");
    chk(3, 0, 0, "R10 status after reset");

    // plain countdown
    wr(2, IE); wr(0, 5);
    ticks(4);
    chk(0, 1, 0, "R1 count after four strobes");
    chk(3, 0, 0, "R2 no event before zero");
    ticks(1);
    chk(0, 0, 1, "R2 count reaches zero");
    chk(3, DIS, 1, "R3 status set on expiry");
    ticks(3);
    chk(0, 0, 1, "R2 parked at zero");
    wr(3, 0);
    chk(3, DIS, 1, "R6 zero write keeps status");
    wr(3, DIS);
    chk(3, 0, 0, "R6 one write clears status");
    ticks(3);
    chk(3, 0, 0, "R2 single event per zero");

    // status without enable, then gating
    wr(2, 0); wr(0, 2);
    ticks(2);
    chk(3, DIS, 0, "R3 status set with interrupt disabled");
    wr(2, IE);
    chk(3, DIS, 1, "R7 enable gates irq on");
    wr(3, 32'hFFFF_FFFF);
    chk(3, 0, 0, "R6 all-ones write clears");

    // auto-reload
    wr(1, 3); wr(2, IE | ARE); wr(0, 2);
    ticks(2);
    chk(0, 3, 1, "R4 reload on expiry");
    chk(1, 3, 1, "R9 reload readback");
    wr(3, DIS);
    ticks(2);
    chk(0, 1, 0, "R4 reloaded count decrements");
    ticks(1);
    chk(0, 3, 1, "R4 second periodic event");
    wr(3, DIS);

    // zero reload
    wr(1, 0); wr(0, 1);
    ticks(1);
    chk(0, 0, 1, "R5 zero reload parks count");
    wr(3, DIS);
    ticks(4);
    chk(0, 0, 0, "R5 no retrigger with zero reload");

    // load priority
    wr(1, 7); wr(0, 1);
    rate_tick = 1'b1; wr(0, 9); rate_tick = 1'b0;
    chk(0, 9, 0, "R8 load wins over expiry");
    chk(3, 0, 0, "R8 no event on load cycle");

    // hold without strobe
    repeat (5) @(negedge clk);
    chk(0, 9, 0, "R1 hold without strobe");
    ticks(3);
    chk(0, 6, 0, "R1 burst of three strobes");

    // set beats clear
    wr(0, 1);
    rate_tick = 1'b1; wr(3, DIS); rate_tick = 1'b0;
    chk(3, DIS, 1, "R6 expiry beats clear");
    chk(0, 7, 1, "R4 reload alongside clear");

    // control readback
    wr(2, 32'hFFFF_FFFF);
    chk(2, IE | ARE, 1, "R9 control implemented bits only");

    // mid-run reset
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk(2, 0, 0, "R10 ctrl cleared by reset");
    chk(3, 0, 0, "R10 status cleared by reset");
    chk(0, 0, 0, "R10 count cleared by reset");
    chk(1, 0, 0, "R10 reload cleared by reset");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule